// File: doc/BRIEF.md
# Multi-Tap Line Readout Sequencer

This block holds one scan line in a small internal pixel store and plays it out on eight parallel output lanes. Each lane follows its own pixel order. The line is cut into four equal quarters. Each quarter is shared by two lanes: one takes the pixels at even 0-based positions and the other takes those at odd positions. The lower two quarters are walked upward. The upper two quarters are walked downward, from the last pixel of the quarter to the first.

A narrow mode runs on four lanes instead of eight. Each of these lanes carries a neighbouring tap pair, alternating between the two taps on successive cycles, so the line takes twice as many cycles. The output word can be cut to 8 or 10 bits by dropping the low bits of the stored 12-bit value. A ramp test pattern can stand in for the stored data.

A host fills the store through a simple write port. It then pulses `start` to read out one line, framed by the `lval` line-valid strobe.

Top module: `line_tap_seq`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at pixel `wr_addr` (0-based). Any later readout shows the stored value.
- R2: In eight-lane mode, with LINE_LEN = 4*S and step k running from 0 to S/2-1, lane t < 4 carries pixel (t/2)*S + 2k + (t mod 2).
- R3: In eight-lane mode, lane t ≥ 4 carries pixel (t/2)*S + S-2 - 2k + (t mod 2). The upper quarters are therefore walked in descending order.
- R4: When `narrow` is 1, lane c (0..3) carries tap 2c on even steps and tap 2c+1 on odd steps. The tap index is step/2, and lanes 4..7 are zero.
- R5: After an idle `start`, `lval` rises at the next clock edge. It stays high for exactly S/2 cycles in eight-lane mode or S cycles in narrow mode, then falls.
- R6: `dval` is always 1 and `fval` is always 0.
- R7: `wsel` picks the output width: 0 gives 8 bits (stored bits 11:4), 1 gives 10 bits (bits 11:2), and 2 or 3 gives 12 bits. The result is right-aligned in the 12-bit lane.
- R8: When `pat` is 1, each active lane carries its pixel index modulo 2^W, where W is the selected width.
- R9: A `start` while `lval` is high is ignored: the line length and data are unchanged. It also sets `overrun`, which stays 1 until reset.
- R10: `narrow`, `wsel` and `pat` are sampled at `start`. Whenever `lval` is low, all lanes are zero. After reset, `lval` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Pixel store write enable |
| wr_addr | input | $clog2(LINE_LEN) | Pixel index to write |
| wr_data | input | 12 | Pixel value to write |
| start | input | 1 | Begin reading one line |
| narrow | input | 1 | 1 = four-lane paired mode |
| wsel | input | 2 | Output width select |
| pat | input | 1 | 1 = ramp test pattern |
| lval | output | 1 | Line valid |
| dval | output | 1 | Data valid, tied high |
| fval | output | 1 | Frame valid, tied low |
| overrun | output | 1 | Sticky: start seen during readout |
| tap_data | output | 96 | Eight 12-bit lanes, lane 0 in bits 11:0 |

## Verification
The bench sweeps every combination of lane mode, width and source over a line filled with distinct values. It checks every lane on every step against an address formula.

- An off-by-one in the descending walk would shift the upper lanes by one pixel, or start them on the wrong parity.
- A swapped pair phase in narrow mode would exchange neighbouring pixels.
- A wrong truncation would show up as low-order residue in 8- or 10-bit words.

A start injected mid-line must leave the line length and data untouched while raising the sticky flag. A design that restarted the counter would produce an overlong `lval`.

// File: rtl/line_tap_seq.sv
module line_tap_seq #(
  parameter int LINE_LEN = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(LINE_LEN)-1:0] wr_addr,
  input  logic [11:0]                 wr_data,
  input  logic                        start,
  input  logic                        narrow,
  input  logic [1:0]                  wsel,
  input  logic                        pat,
  output logic                        lval,
  output logic                        dval,
  output logic                        fval,
  output logic                        overrun,
  output logic [95:0]                 tap_data
);
  localparam int AW   = $clog2(LINE_LEN);
  localparam int SEG  = LINE_LEN / 4;
  localparam int HALF = SEG / 2;
  localparam int CW   = $clog2(SEG) + 1;

  logic [11:0]   mem [LINE_LEN];
  logic [CW-1:0] cnt;
  logic          narrow_q, pat_q;
  logic [1:0]    wsel_q;
  logic [CW-1:0] last;

  assign last = narrow_q ? CW'(SEG - 1) : CW'(HALF - 1);
  assign dval = 1'b1;
  assign fval = 1'b0;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lval     <= 1'b0;
      cnt      <= '0;
      overrun  <= 1'b0;
      narrow_q <= 1'b0;
      wsel_q   <= 2'd2;
      pat_q    <= 1'b0;
    end else if (!lval) begin
      if (start) begin
        lval     <= 1'b1;
        cnt      <= '0;
        narrow_q <= narrow;
        wsel_q   <= wsel;
        pat_q    <= pat;
      end
    end else begin
      if (start) overrun <= 1'b1;
      if (cnt == last) lval <= 1'b0;
      else cnt <= cnt + 1'b1;
    end
  end

  function automatic int pix_of(input int t, input int k);
    int seg, par;
    seg = t / 2;
    par = t % 2;
    if (seg < 2) return seg * SEG + 2 * k + par;
    else         return seg * SEG + SEG - 2 - 2 * k + par;
  endfunction

  function automatic logic [11:0] shape(input logic [11:0] raw, input int idx,
                                        input logic [1:0] ws, input logic p);
    logic [11:0] v;
    if (p) begin
      case (ws)
        2'd0:    v = 12'(idx % 256);
        2'd1:    v = 12'(idx % 1024);
        default: v = 12'(idx % 4096);
      endcase
    end else begin
      case (ws)
        2'd0:    v = {4'b0, raw[11:4]};
        2'd1:    v = {2'b0, raw[11:2]};
        default: v = raw;
      endcase
    end
    return v;
  endfunction

  for (genvar l = 0; l < 8; l++) begin : g_lane
    int          tap, step, idx;
    logic        on;
    logic [11:0] raw;
    always_comb begin
      if (narrow_q) begin
        tap  = 2 * l + int'(cnt[0]);
        step = int'(cnt >> 1);
        on   = lval && (l < 4);
      end else begin
        tap  = l;
        step = int'(cnt);
        on   = lval;
      end
      idx = on ? pix_of(tap, step) : 0;
      raw = mem[AW'(idx)];
      tap_data[12*l +: 12] = on ? shape(raw, idx, wsel_q, pat_q) : 12'd0;
    end
  end

  logic [CW:0] runlen;
  always_ff @(posedge clk)
    if (!rst_n || !lval) runlen <= '0;
    else runlen <= runlen + 1'b1;

  AST_DVAL_FVAL: assert property (@(posedge clk) dval && !fval); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overrun |=> overrun); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && start && cnt != last) |=> (lval && overrun && $stable(narrow_q))); // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !lval |-> tap_data == '0); // R10
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (lval && narrow_q) |-> tap_data[95:48] == '0); // R4
  AST_LINE_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    lval |-> runlen < (narrow_q ? (CW+1)'(SEG) : (CW+1)'(HALF))); // R5
  AST_LINE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lval) |-> $past(runlen) == (narrow_q ? (CW+1)'(SEG - 1) : (CW+1)'(HALF - 1))); // R5
endmodule

// File: tb/line_tap_seq_bench.sv
`timescale 1ns/1ps
module line_tap_seq_bench;
  localparam int LINE_LEN = 64;
  localparam int AW = $clog2(LINE_LEN);
  localparam int SEG = LINE_LEN / 4;

  logic clk = 0, rst_n = 0, wr_en = 0, start = 0, narrow = 0, pat = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [1:0] wsel = 2'd2;
  logic lval, dval, fval, overrun;
  logic [95:0] tap_data;
  int total = 0, bad = 0;
  logic [11:0] model [LINE_LEN];

  always #2.5 clk = ~clk;

  line_tap_seq #(.LINE_LEN(LINE_LEN)) u_line_tap_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start(start), .narrow(narrow), .wsel(wsel), .pat(pat),
    .lval(lval), .dval(dval), .fval(fval), .overrun(overrun), .tap_data(tap_data));

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [11:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; model[a] = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic int exp_lane(input int l, input int s, input logic n,
                                  input logic [1:0] w, input logic p);
    int t, k, seg, par, idx, bits;
    if (n) begin
      if (l >= 4) return 0;
      t = 2 * l + (s % 2); k = s / 2;
    end else begin
      t = l; k = s;
    end
    seg = t / 2; par = t % 2;
    idx = (seg < 2) ? seg * SEG + 2 * k + par : seg * SEG + SEG - 2 - 2 * k + par;
    bits = (w == 0) ? 8 : (w == 1) ? 10 : 12;
    if (p) return idx % (1 << bits);
    return int'(model[idx]) >> (12 - bits);
  endfunction

  function automatic string tag(input int l, input logic n, input logic [1:0] w, input logic p);
    if (n) return "R4";
    if (p) return "R8";
    if (w < 2) return "R7";
    return (l < 4) ? "R2" : "R3";
  endfunction

  task automatic run_line(input logic n, input logic [1:0] w, input logic p,
                          input int inject_at, input string force_tag);
    int steps;
    steps = n ? SEG : SEG / 2;
    @(negedge clk);
    narrow = n; wsel = w; pat = p; start = 1;
    @(negedge clk);
    start = 0; narrow = ~n; wsel = 2'd0; pat = ~p;
    for (int s = 0; s < steps; s++) begin
      if (s > 0) @(negedge clk);
      start = (s == inject_at);
      chk("R5", lval, 1);
      chk("R6", {dval, fval}, 2'b10);
      for (int l = 0; l < 8; l++)
        chk(force_tag.len() > 0 ? force_tag : tag(l, n, w, p),
            tap_data[12*l +: 12], exp_lane(l, s, n, w, p));
    end
    @(negedge clk);
    start = 0;
    chk("R5", lval, 0);
    chk("R10", tap_data, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", lval, 0);
    chk("R10", overrun, 0);
    chk("R10", tap_data, 0);
    rst_n = 1;
    for (int i = 0; i < LINE_LEN; i++) wr(i, 12'((i * 173 + 91) % 4096));
    for (int n = 0; n < 2; n++)
      for (int w = 0; w < 4; w++)
        for (int p = 0; p < 2; p++)
          run_line(n[0], w[1:0], p[0], -1, "");
    chk("R9", overrun, 0);
    run_line(1'b0, 2'd2, 1'b0, 3, "R9");
    chk("R9", overrun, 1);
    run_line(1'b1, 2'd1, 1'b0, 5, "R9");
    chk("R9", overrun, 1);
    wr(0, 12'hA5C);
    wr(LINE_LEN - 1, 12'h3E7);
    wr(SEG * 2 + SEG - 2, 12'hFFF);
    run_line(1'b0, 2'd2, 1'b0, -1, "R1");
    run_line(1'b1, 2'd0, 1'b0, -1, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule